// File: doc/BRIEF.md
# Flash Write Request Splitter

This block accepts one host write request, given as a starting byte address and a byte count, aimed at a bank of identical parallel flash devices. It cuts the request into sub-requests for two downstream engines. One engine programs single bus words. The other engine programs through the device write buffer. The block decides which engine gets each piece and how long each piece is. It also tracks the targeted device and the offset inside that device, and it returns the number of bytes written once the request ends.

A start address that is not aligned to the bus width first produces a short head piece for the word engine. That head brings the offset onto a bus boundary. After the head, buffered pieces are issued. Each buffered piece stops at the next write-buffer boundary, so it never spans two buffers. When the offset reaches the end of a device, the device index steps forward and the offset returns to zero. A request that runs past the last device ends successfully at that point. Only one sub-request is outstanding at a time. The first failure reported by an engine ends the whole request and forwards that failure's code.

Top module: `flash_wr_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `wp_valid`, `bp_valid` and `cpl_valid` are all 0.
- R2: A request with `req_len` 0 issues no sub-request and completes with `cpl_ok`=1 and `cpl_bytes`=0.
- R3: The address splits into a device index (`req_addr` >> CHIP_SHIFT) and an offset inside the device (the low CHIP_SHIFT bits). If that offset is not a multiple of BUS_BYTES, the first piece goes to the word engine. The word engine is used only in this case, and this piece has length (BUS_BYTES − offset mod BUS_BYTES), capped at `req_len`.
- R4: Every other piece goes to the buffer engine. Its length is WBUF_BYTES − (offset mod WBUF_BYTES), capped at the remaining byte count, where WBUF_BYTES = INTERLEAVE << BUF_SHIFT. So a buffered piece never crosses a write-buffer boundary.
- R5: When a piece ends exactly at the end of a device (offset reaches 2^CHIP_SHIFT), the next piece targets the next device index at offset 0.
- R6: When the last device (index NUM_CHIPS−1) is filled to its end, the request completes with `cpl_ok`=1, even if bytes remain. `cpl_bytes` then equals the bytes written so far.
- R7: If a piece is acknowledged with its `*_fail` set, no further piece is issued. The request completes with `cpl_ok`=0, `cpl_code` equal to that piece's code, and `cpl_bytes` equal to the bytes of the pieces that succeeded before it.
- R8: Each `*_valid` lasts one cycle, and at most one piece is outstanding. Only the `*_done` of the engine that holds the outstanding piece is taken. A `*_done` from the other engine, or one that arrives while no piece is outstanding, has no effect.
- R9: `cpl_valid` is a single-cycle pulse. On success, `cpl_bytes` equals `req_len`, or the bytes up to the end of the last device if that is smaller, and `cpl_code` is 0.
- R10: A request is accepted only when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from acceptance until the completion pulse, so a request presented while the block is busy is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | CHIP_SHIFT+CHIP_W | Start byte address across the device bank |
| req_len | input | LEN_W | Byte count to write |
| wp_valid | output | 1 | Issue a piece to the word engine |
| wp_chip | output | CHIP_W | Device index of the piece |
| wp_ofs | output | CHIP_SHIFT | Offset inside the device |
| wp_len | output | LEN_W | Piece length in bytes |
| wp_done | input | 1 | Word engine finished the outstanding piece |
| wp_fail | input | 1 | With `wp_done`: the piece failed |
| wp_code | input | CODE_W | With `wp_done`: failure code |
| bp_valid | output | 1 | Issue a piece to the buffer engine |
| bp_chip | output | CHIP_W | Device index of the piece |
| bp_ofs | output | CHIP_SHIFT | Offset inside the device |
| bp_len | output | LEN_W | Piece length in bytes |
| bp_done | input | 1 | Buffer engine finished the outstanding piece |
| bp_fail | input | 1 | With `bp_done`: the piece failed |
| bp_code | input | CODE_W | With `bp_done`: failure code |
| cpl_valid | output | 1 | Request complete (one cycle) |
| cpl_ok | output | 1 | Request succeeded |
| cpl_code | output | CODE_W | Failure code, 0 on success |
| cpl_bytes | output | LEN_W | Bytes written successfully |

## Verification
The bench covers the following boundary cases.

- **Odd start address.** A request that starts on an odd address must produce a one-byte head on the word engine. A design that skipped the head would hand a misaligned offset to the buffer engine.
- **Start two bytes before a device boundary.** The bench starts a request this close to the end of a device. A design that mishandled the wrap would either issue a piece that spans two devices or restart at the wrong device index.
- **Run past the last device.** A request that runs off the end of the last device must stop with success and a short byte count. A design that kept going would issue pieces to a device index that does not exist.
- **Failing pieces and stray acknowledgements.** The bench fails a head piece and also fails a buffered piece partway through a request. These runs show whether the byte count leaks the failed piece and whether anything is issued after the failure. An acknowledgement flagged as failed is also driven on the idle engine before every real one. A design that took it would abort requests that should succeed.

// File: rtl/fws_pkg.sv
// Shared types for the flash write splitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fws_pkg;

    // Controller phases: wait for host, choose next piece, issue it, wait for it, report.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_NEXT  = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_FIN   = 3'd4
    } fws_state_t;

    // Downstream engine selected for a piece.
    typedef enum logic {
        PATH_WORD = 1'b0,
        PATH_BUF  = 1'b1
    } fws_path_t;

endpackage

// File: rtl/fws_piece_calc.sv
// fws_piece_calc: purely combinational sizing of the next piece.
// Given the low offset bits inside the device and the remaining byte count,
// it picks the engine and the piece length.
// Assumes BUS_BYTES and WBUF_BYTES are powers of two, WBUF_BYTES >= 2,
// and WBUF_BYTES >= BUS_BYTES.
module fws_piece_calc
    import fws_pkg::*;
#(
    parameter int BUS_BYTES  = 2,
    parameter int WBUF_BYTES = 16,
    parameter int LEN_W      = 12,
    localparam int BUS_LOG2  = $clog2(BUS_BYTES),
    localparam int WBUF_LOG2 = $clog2(WBUF_BYTES)
) (
    input  logic [WBUF_LOG2-1:0] ofs_low,
    input  logic [LEN_W-1:0]     rem,
    output fws_path_t            path,
    output logic [LEN_W-1:0]     len
);

    logic             misaligned;
    logic [LEN_W-1:0] head_room;
    logic [LEN_W-1:0] buf_room;
    logic [LEN_W-1:0] room;

    // Head detection exists only when the bus is wider than one byte.
    generate
        if (BUS_LOG2 == 0) begin : g_byte_bus
            assign misaligned = 1'b0;
            assign head_room  = '0;
        end else begin : g_wide_bus
            logic [BUS_LOG2-1:0] in_word;
            assign in_word    = ofs_low[BUS_LOG2-1:0];
            assign misaligned = (in_word != '0);
            assign head_room  = LEN_W'(BUS_BYTES) - LEN_W'(in_word);
        end
    endgenerate

    // Room left before the next write-buffer boundary.
    assign buf_room = LEN_W'(WBUF_BYTES) - LEN_W'(ofs_low);

    // Choose engine and clip the room to what is left of the request.
    always_comb begin
        path = misaligned ? PATH_WORD : PATH_BUF;
        room = misaligned ? head_room : buf_room;
        len  = (rem < room) ? rem : room;
    end

endmodule

// File: rtl/fws_pos_track.sv
// fws_pos_track: holds device index, offset, remaining bytes and bytes done.
// A load starts a request; a step advances by one finished piece, wrapping
// to the next device at its end and flagging the end of the bank.
// Assumes a piece never crosses a device end (buffer size divides device size).
module fws_pos_track #(
    parameter int NUM_CHIPS  = 4,
    parameter int CHIP_SHIFT = 6,
    parameter int LEN_W      = 12,
    localparam int CHIP_W    = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
    localparam int SUM_W     = CHIP_SHIFT + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [CHIP_W-1:0]     load_chip,
    input  logic [CHIP_SHIFT-1:0] load_ofs,
    input  logic [LEN_W-1:0]      load_len,
    input  logic                  step,
    input  logic [LEN_W-1:0]      step_len,
    output logic [CHIP_W-1:0]     chip,
    output logic [CHIP_SHIFT-1:0] ofs,
    output logic [LEN_W-1:0]      rem,
    output logic [LEN_W-1:0]      bytes,
    output logic                  all_done
);

    localparam logic [CHIP_W-1:0] LAST_CHIP = CHIP_W'(NUM_CHIPS - 1);

    logic             bank_end;
    logic [SUM_W-1:0] next_sum;
    logic             wraps;

    // Offset after the current piece, one bit wider to see the device end.
    always_comb begin
        next_sum = {1'b0, ofs} + SUM_W'(step_len);
        wraps    = next_sum[CHIP_SHIFT];
    end

    // Position registers: load on accept, advance on each good piece.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip     <= '0;
            ofs      <= '0;
            rem      <= '0;
            bytes    <= '0;
            bank_end <= 1'b0;
        end else if (load) begin
            chip     <= load_chip;
            ofs      <= load_ofs;
            rem      <= load_len;
            bytes    <= '0;
            bank_end <= (load_chip > LAST_CHIP);
        end else if (step) begin
            rem   <= rem - step_len;
            bytes <= bytes + step_len;
            if (wraps) begin
                ofs <= '0;
                if (chip == LAST_CHIP) begin
                    bank_end <= 1'b1;
                end else begin
                    chip <= chip + 1'b1;
                end
            end else begin
                ofs <= next_sum[CHIP_SHIFT-1:0];
            end
        end
    end

    assign all_done = bank_end || (rem == '0);

endmodule

// File: rtl/fws_ctrl.sv
// fws_ctrl: sequences one request through pieces, one outstanding at a time.
// Accepts only the acknowledgement of the engine holding the current piece,
// and stops at the first failed piece.
// Assumes engines raise done no earlier than the cycle after the issue pulse.
module fws_ctrl
    import fws_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              all_done,
    input  fws_path_t         sel_path,
    input  logic              wp_done,
    input  logic              wp_fail,
    input  logic [CODE_W-1:0] wp_code,
    input  logic              bp_done,
    input  logic              bp_fail,
    input  logic [CODE_W-1:0] bp_code,
    output logic              req_ready,
    output logic              load,
    output logic              step,
    output logic              issue_word,
    output logic              issue_buf,
    output logic              cpl_valid,
    output logic              cpl_ok,
    output logic [CODE_W-1:0] cpl_code
);

    fws_state_t        st;
    fws_path_t         path_q;
    logic              hit;
    logic              hit_fail;
    logic [CODE_W-1:0] hit_code;

    // Pick the acknowledgement belonging to the outstanding piece only.
    always_comb begin
        if (path_q == PATH_WORD) begin
            hit      = (st == ST_WAIT) && wp_done;
            hit_fail = wp_fail;
            hit_code = wp_code;
        end else begin
            hit      = (st == ST_WAIT) && bp_done;
            hit_fail = bp_fail;
            hit_code = bp_code;
        end
    end

    // Phase register plus latched engine choice and final status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            path_q   <= PATH_BUF;
            cpl_ok   <= 1'b0;
            cpl_code <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        st       <= ST_NEXT;
                        cpl_ok   <= 1'b1;
                        cpl_code <= '0;
                    end
                end
                ST_NEXT: begin
                    path_q <= sel_path;
                    st     <= all_done ? ST_FIN : ST_ISSUE;
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: begin
                    if (hit) begin
                        if (hit_fail) begin
                            cpl_ok   <= 1'b0;
                            cpl_code <= hit_code;
                            st       <= ST_FIN;
                        end else begin
                            st <= ST_NEXT;
                        end
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Strobes derived from the phase.
    always_comb begin
        req_ready  = (st == ST_IDLE);
        load       = (st == ST_IDLE) && req_valid;
        step       = hit && !hit_fail;
        issue_word = (st == ST_ISSUE) && (path_q == PATH_WORD);
        issue_buf  = (st == ST_ISSUE) && (path_q == PATH_BUF);
        cpl_valid  = (st == ST_FIN);
    end

endmodule

// File: rtl/flash_wr_splitter.sv
// flash_wr_splitter: top level. Splits a host write into a misaligned head
// for the word engine and buffer-bounded pieces for the buffer engine,
// walking across a bank of NUM_CHIPS identical devices.
// Assumes all sizes are powers of two, BUS_BYTES <= WBUF_BYTES <= device size,
// and LEN_W > CHIP_SHIFT is not required but LEN_W must hold WBUF_BYTES.
module flash_wr_splitter
    import fws_pkg::*;
#(
    parameter int BUS_BYTES  = 2,
    parameter int INTERLEAVE = 1,
    parameter int BUF_SHIFT  = 4,
    parameter int CHIP_SHIFT = 6,
    parameter int NUM_CHIPS  = 4,
    parameter int LEN_W      = 12,
    parameter int CODE_W     = 4,
    localparam int WBUF_BYTES = INTERLEAVE << BUF_SHIFT,
    localparam int WBUF_LOG2  = $clog2(WBUF_BYTES),
    localparam int CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1,
    localparam int ADDR_W     = CHIP_SHIFT + CHIP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [LEN_W-1:0]      req_len,
    output logic                  wp_valid,
    output logic [CHIP_W-1:0]     wp_chip,
    output logic [CHIP_SHIFT-1:0] wp_ofs,
    output logic [LEN_W-1:0]      wp_len,
    input  logic                  wp_done,
    input  logic                  wp_fail,
    input  logic [CODE_W-1:0]     wp_code,
    output logic                  bp_valid,
    output logic [CHIP_W-1:0]     bp_chip,
    output logic [CHIP_SHIFT-1:0] bp_ofs,
    output logic [LEN_W-1:0]      bp_len,
    input  logic                  bp_done,
    input  logic                  bp_fail,
    input  logic [CODE_W-1:0]     bp_code,
    output logic                  cpl_valid,
    output logic                  cpl_ok,
    output logic [CODE_W-1:0]     cpl_code,
    output logic [LEN_W-1:0]      cpl_bytes
);

    logic                  load;
    logic                  step;
    logic                  all_done;
    logic [CHIP_W-1:0]     cur_chip;
    logic [CHIP_SHIFT-1:0] cur_ofs;
    logic [LEN_W-1:0]      cur_rem;
    logic [LEN_W-1:0]      cur_bytes;
    fws_path_t             sel_path;
    logic [LEN_W-1:0]      piece_len;
    logic                  issue_word;
    logic                  issue_buf;

    fws_pos_track #(
        .NUM_CHIPS (NUM_CHIPS),
        .CHIP_SHIFT(CHIP_SHIFT),
        .LEN_W     (LEN_W)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_chip(req_addr[ADDR_W-1:CHIP_SHIFT]),
        .load_ofs (req_addr[CHIP_SHIFT-1:0]),
        .load_len (req_len),
        .step     (step),
        .step_len (piece_len),
        .chip     (cur_chip),
        .ofs      (cur_ofs),
        .rem      (cur_rem),
        .bytes    (cur_bytes),
        .all_done (all_done)
    );

    fws_piece_calc #(
        .BUS_BYTES (BUS_BYTES),
        .WBUF_BYTES(WBUF_BYTES),
        .LEN_W     (LEN_W)
    ) u_calc (
        .ofs_low(cur_ofs[WBUF_LOG2-1:0]),
        .rem    (cur_rem),
        .path   (sel_path),
        .len    (piece_len)
    );

    fws_ctrl #(
        .CODE_W(CODE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .all_done  (all_done),
        .sel_path  (sel_path),
        .wp_done   (wp_done),
        .wp_fail   (wp_fail),
        .wp_code   (wp_code),
        .bp_done   (bp_done),
        .bp_fail   (bp_fail),
        .bp_code   (bp_code),
        .req_ready (req_ready),
        .load      (load),
        .step      (step),
        .issue_word(issue_word),
        .issue_buf (issue_buf),
        .cpl_valid (cpl_valid),
        .cpl_ok    (cpl_ok),
        .cpl_code  (cpl_code)
    );

    // Piece fields are shared; only the valid strobe selects the engine.
    always_comb begin
        wp_valid  = issue_word;
        wp_chip   = cur_chip;
        wp_ofs    = cur_ofs;
        wp_len    = piece_len;
        bp_valid  = issue_buf;
        bp_chip   = cur_chip;
        bp_ofs    = cur_ofs;
        bp_len    = piece_len;
        cpl_bytes = cur_bytes;
    end

endmodule

// File: rtl/fws_checker.sv
// fws_checker: protocol properties for flash_wr_splitter, attached by bind.
// Tracks the outstanding piece and a seen-failure flag from port activity.
module fws_checker #(
    parameter int BUS_BYTES  = 2,
    parameter int WBUF_BYTES = 16,
    parameter int CHIP_SHIFT = 6,
    parameter int LEN_W      = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_ready,
    input logic                  wp_valid,
    input logic [CHIP_SHIFT-1:0] wp_ofs,
    input logic [LEN_W-1:0]      wp_len,
    input logic                  wp_done,
    input logic                  wp_fail,
    input logic                  bp_valid,
    input logic [CHIP_SHIFT-1:0] bp_ofs,
    input logic [LEN_W-1:0]      bp_len,
    input logic                  bp_done,
    input logic                  bp_fail,
    input logic                  cpl_valid
);

    logic out_word;
    logic out_buf;
    logic fail_seen;

    // Shadow of the outstanding piece and of a taken failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= 1'b0;
            out_buf   <= 1'b0;
            fail_seen <= 1'b0;
        end else begin
            if (wp_valid) out_word <= 1'b1;
            else if (out_word && wp_done) begin
                out_word <= 1'b0;
                if (wp_fail) fail_seen <= 1'b1;
            end
            if (bp_valid) out_buf <= 1'b1;
            else if (out_buf && bp_done) begin
                out_buf <= 1'b0;
                if (bp_fail) fail_seen <= 1'b1;
            end
            if (cpl_valid) fail_seen <= 1'b0;
        end
    end

    AST_SINGLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_valid && bp_valid)); // R8
    AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_valid || bp_valid) |=> !(wp_valid || bp_valid)); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_valid || bp_valid) |-> !(out_word || out_buf)); // R8
    AST_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        wp_valid |-> (wp_len != '0 && int'(wp_len) < BUS_BYTES)); // R3
    AST_WORD_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wp_valid |-> (int'(wp_ofs) % BUS_BYTES != 0)); // R3
    AST_BUF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bp_valid |-> (int'(bp_ofs) % BUS_BYTES == 0)); // R4
    AST_BUF_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        bp_valid |-> (bp_len != '0 &&
                      (int'(bp_ofs) % WBUF_BYTES) + int'(bp_len) <= WBUF_BYTES)); // R4
    AST_FAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        fail_seen |-> !(wp_valid || bp_valid)); // R7
    AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> !cpl_valid); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_valid || bp_valid || out_word || out_buf) |-> !req_ready); // R10

endmodule

bind flash_wr_splitter fws_checker #(
    .BUS_BYTES (BUS_BYTES),
    .WBUF_BYTES(INTERLEAVE << BUF_SHIFT),
    .CHIP_SHIFT(CHIP_SHIFT),
    .LEN_W     (LEN_W)
) u_fws_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .wp_valid (wp_valid),
    .wp_ofs   (wp_ofs),
    .wp_len   (wp_len),
    .wp_done  (wp_done),
    .wp_fail  (wp_fail),
    .bp_valid (bp_valid),
    .bp_ofs   (bp_ofs),
    .bp_len   (bp_len),
    .bp_done  (bp_done),
    .bp_fail  (bp_fail),
    .cpl_valid(cpl_valid)
);

// File: tb/test_flash_wr_splitter.sv
// Bench for flash_wr_splitter with default parameters:
// 2-byte bus, 16-byte write buffer, 64-byte devices, 4 devices.
module test_flash_wr_splitter;

    localparam int BW = 2, WB = 16, CS = 64, NC = 4;

    typedef struct packed {
        logic [7:0]  addr;
        logic [11:0] len;
        logic [3:0]  fail_at;   // piece index that fails, 15 = none
        logic [3:0]  code;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 12'd0,   4'hF, 4'h0},  // R2 zero length
        '{8'h03, 12'd1,   4'hF, 4'h0},  // R3 head capped at length
        '{8'h05, 12'd20,  4'hF, 4'h0},  // R3 R4 head then chunks
        '{8'h3E, 12'd40,  4'hF, 4'h0},  // R5 device wrap
        '{8'hF9, 12'd100, 4'hF, 4'h0},  // R6 end of bank
        '{8'h10, 12'd48,  4'd1, 4'hA},  // R7 fail on second chunk
        '{8'h01, 12'd5,   4'd0, 4'h6}   // R7 fail on head
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [11:0] req_len = '0;
    logic        wp_valid, bp_valid, cpl_valid, cpl_ok;
    logic [1:0]  wp_chip, bp_chip;
    logic [5:0]  wp_ofs, bp_ofs;
    logic [11:0] wp_len, bp_len, cpl_bytes;
    logic        wp_done = 0, wp_fail = 0, bp_done = 0, bp_fail = 0;
    logic [3:0]  wp_code = 0, bp_code = 0, cpl_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    flash_wr_splitter i_flash_wr_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .wp_valid(wp_valid), .wp_chip(wp_chip), .wp_ofs(wp_ofs), .wp_len(wp_len),
        .wp_done(wp_done), .wp_fail(wp_fail), .wp_code(wp_code),
        .bp_valid(bp_valid), .bp_chip(bp_chip), .bp_ofs(bp_ofs), .bp_len(bp_len),
        .bp_done(bp_done), .bp_fail(bp_fail), .bp_code(bp_code),
        .cpl_valid(cpl_valid), .cpl_ok(cpl_ok), .cpl_code(cpl_code),
        .cpl_bytes(cpl_bytes)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_vec(input vec_t v);
        int  m_chip = int'(v.addr) / CS;
        int  m_ofs  = int'(v.addr) % CS;
        int  m_rem  = int'(v.len);
        int  m_bytes = 0;
        bit  m_end  = 0;
        bit  m_fail = 0;
        int  idx = 0;
        bit  fin = 0;
        int  guard = 0;
        @(negedge clk);
        req_addr  = v.addr;
        req_len   = v.len;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin && guard < 2000) begin
            guard++;
            if (wp_valid || bp_valid) begin
                bit exp_word = (m_ofs % BW) != 0;
                int room = exp_word ? (BW - m_ofs % BW) : (WB - m_ofs % WB);
                int exp_len = (m_rem < room) ? m_rem : room;
                bit fail_now = (idx == int'(v.fail_at));
                check(!(m_end || m_rem == 0 || m_fail), "R6 R7 no extra piece", idx, -1);
                check(wp_valid == exp_word, exp_word ? "R3 word path" : "R4 buffer path",
                      int'(wp_valid), int'(exp_word));
                check(int'(exp_word ? wp_chip : bp_chip) == m_chip, "R5 chip", 
                      int'(exp_word ? wp_chip : bp_chip), m_chip);
                check(int'(exp_word ? wp_ofs : bp_ofs) == m_ofs, "R5 offset",
                      int'(exp_word ? wp_ofs : bp_ofs), m_ofs);
                check(int'(exp_word ? wp_len : bp_len) == exp_len,
                      exp_word ? "R3 head length" : "R4 chunk length",
                      int'(exp_word ? wp_len : bp_len), exp_len);
                check(req_ready == 1'b0, "R10 ready low while busy", int'(req_ready), 0);
                // R8 stray failing ack on the other engine, plus a busy request
                @(negedge clk);
                if (exp_word) begin bp_done = 1; bp_fail = 1; bp_code = 4'hF; end
                else          begin wp_done = 1; wp_fail = 1; wp_code = 4'hF; end
                req_valid = 1'b1;
                @(negedge clk);
                bp_done = 0; bp_fail = 0; wp_done = 0; wp_fail = 0;
                req_valid = 1'b0;
                check(!(wp_valid || bp_valid || cpl_valid), "R8 stray ack ignored",
                      int'(cpl_valid), 0);
                if (exp_word) begin wp_done = 1; wp_fail = fail_now; wp_code = v.code; end
                else          begin bp_done = 1; bp_fail = fail_now; bp_code = v.code; end
                @(negedge clk);
                wp_done = 0; wp_fail = 0; bp_done = 0; bp_fail = 0;
                if (fail_now) m_fail = 1;
                else begin
                    m_ofs += exp_len; m_rem -= exp_len; m_bytes += exp_len;
                    if (m_ofs == CS) begin
                        if (m_chip == NC - 1) m_end = 1;
                        else begin m_chip++; m_ofs = 0; end
                    end
                end
                idx++;
            end else if (cpl_valid) begin
                check(cpl_ok == !m_fail, "R7 R9 completion status", int'(cpl_ok), int'(!m_fail));
                check(int'(cpl_bytes) == m_bytes, "R6 R7 R9 byte count", int'(cpl_bytes), m_bytes);
                check(cpl_code == (m_fail ? v.code : 4'h0), "R7 code",
                      int'(cpl_code), int'(m_fail ? v.code : 4'h0));
                check(m_end || m_rem == 0 || m_fail, "R2 R6 completion timing", m_rem, 0);
                @(negedge clk);
                check(!cpl_valid, "R9 completion pulse", int'(cpl_valid), 0);
                fin = 1;
            end else begin
                @(negedge clk);
            end
        end
        check(fin, "R9 completion seen", int'(fin), 1);
        // R10 busy request must not have been taken
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(!(wp_valid || bp_valid || cpl_valid) && req_ready,
                  "R10 busy request not taken", int'(wp_valid || bp_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(!(wp_valid || bp_valid || cpl_valid), "R1 outputs idle",
              int'(wp_valid || bp_valid || cpl_valid), 0);
        // R8 acknowledgement while idle has no effect
        bp_done = 1; bp_fail = 1; wp_done = 1; wp_fail = 1;
        @(negedge clk);
        bp_done = 0; bp_fail = 0; wp_done = 0; wp_fail = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(req_ready && !cpl_valid && !wp_valid && !bp_valid,
                  "R8 idle ack ignored", int'(cpl_valid), 0);
        end
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // Directed: request starting two bytes before the bank end
        run_vec('{8'hFE, 12'd9, 4'hF, 4'h0});    // R6 single chunk to bank end
        // Directed: reset in the middle of a request
        @(negedge clk);
        req_addr = 8'h20; req_len = 12'd30; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !wp_valid && !bp_valid && !cpl_valid,
              "R1 reset mid request", int'(req_ready), 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule